// File: doc/BRIEF.md
# Menu-Driven SPI Flash Cycle Engine

This block runs single flash cycles on a serial NOR device over a single-bit SPI link in mode 0. Software never supplies a raw opcode. It fills an eight-entry opcode menu and a type word that gives every entry a 2-bit kind. It also sets a prefix opcode, a flash address and a data buffer of up to 64 bytes. It then writes the control register with the go bit set. The cycle engine takes the opcode at the chosen index and sends it. The entry's kind decides whether a 24-bit address follows and whether the data phase sends bytes from the buffer or stores received bytes into it.

An atomic bit puts the prefix opcode, usually a write enable, in front of the main cycle within the same start. Chip select is released for one full SCK period between the two frames. Once the lock register has been set, the menu, type and prefix registers stop accepting writes until reset. A clock-select bit picks the faster of two SCK rates, provided the build allows it.

Register word offsets on `reg_addr`: 0 control, 1 status, 2 address, 3 menu entries 0-3, 4 menu entries 4-7, 5 type, 6 prefix, 7 lock. The upper half of the address space, with the top address bit set, is the data buffer. Word w there holds buffer bytes 4w to 4w+3, least significant byte first.

Top module: `spi_menu_engine`

## Requirements
- R1: After reset the status register reads 0, `spi_csn` is high and `spi_sck` is low.
- R2: The menu is written as two 32-bit words, entries 0-3 at offset 3 and entries 4-7 at offset 4, with entry i in byte i mod 4. A cycle sends the entry chosen by its index as its opcode.
- R3: Type field i sits at bits 2i+1:2i of the type register, with 0 meaning read without address, 1 write without address, 2 read with address and 3 write with address. During a read data phase MOSI is 0 and the received bytes are stored in the buffer.
- R4: Control bit 0 is go, bit 1 atomic, bit 2 fast clock, bits 6:4 the menu index, bit 7 data present, and bits 13:8 the byte count minus one.
- R5: Status bit 0 is cycle in progress, bit 1 done and bit 2 error. Writing 1 to bit 1 or bit 2 clears that flag.
- R6: Only bits 23:0 of the address are stored and sent, most significant byte first. The upper bits read back as 0.
- R7: A data phase moves between 1 and 64 bytes, sent or stored in ascending buffer order.
- R8: Once the lock bit has been written to 1, it stays set until reset, and writes to the menu, type and prefix registers have no effect.
- R9: A cycle without data sends only the opcode, plus the address when its kind has one. It then clears the in-progress flag and sets the done flag.
- R10: A control write with go set while a cycle is in progress is ignored and sets the error flag.
- R11: With the atomic bit set, the prefix opcode goes out in its own chip-select frame, and chip select stays high for at least one SCK period before the main opcode.
- R12: SPI mode 0: SCK idles low, MOSI changes only while SCK is low, MISO is sampled on the rising edge, and every byte is sent most significant bit first.
- R13: SCK stays high for HALF_FAST clock cycles when the fast bit is set and FAST_CAPABLE is 1. Otherwise it stays high for HALF_SLOW cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_sck | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Some properties are checked on every cycle: SCK is low while chip select is high, MOSI holds steady while SCK is high, the lock stays set and the frozen menu does not change, and a control write during a cycle raises the error flag and leaves the latched index alone. A cycle that ends always leaves the done flag set. Other behaviour can only be shown by the bench scenarios. These cover the byte-exact frame content for every kind of entry, the order of data in the buffer for reads and writes, the chip-select gap after the prefix, and the SCK high time at both rates. A flash model in the bench drives MISO to supply the read data.

// File: rtl/spi_menu_engine.sv
module spi_menu_engine #(
  parameter int DATA_BYTES   = 64,
  parameter int HALF_SLOW    = 5,
  parameter int HALF_FAST    = 3,
  parameter bit FAST_CAPABLE = 1'b1,
  parameter int AW           = $clog2(DATA_BYTES) - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_sck,
  output logic          spi_csn,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int CW   = $clog2(DATA_BYTES);
  localparam int DIVW = $clog2(HALF_SLOW + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_STAT = AW'(1), A_ADDR = AW'(2),
    A_MLO = AW'(3), A_MHI = AW'(4), A_TYPE = AW'(5), A_PRE = AW'(6), A_LOCK = AW'(7);

  typedef enum logic [2:0] {PH_IDLE, PH_PRE, PH_GAP, PH_OPC, PH_ADR, PH_DAT} phase_t;

  logic [31:0] menu_lo, menu_hi;
  logic [15:0] type_q;
  logic [7:0]  prefix_q;
  logic        lock_q;
  logic [23:0] addr_q;
  logic        busy_q, done_q, err_q;
  logic [2:0]  idx_q;
  logic        atom_q, fast_q, dp_q;
  logic [CW-1:0] cnt_q, bytecnt;
  phase_t      phase;
  logic [2:0]  bitcnt;
  logic [7:0]  tx_q, rx_q;
  logic        sck_q, csn_q;
  logic [DIVW-1:0] div_q;
  logic [7:0]  dbuf [DATA_BYTES];

  wire [63:0]   menu_all = {menu_hi, menu_lo};
  wire [7:0]    opcode   = menu_all[{idx_q, 3'b000} +: 8];
  wire [7:0]    start_op = menu_all[{reg_wdata[6:4], 3'b000} +: 8];
  wire [1:0]    kind     = type_q[{idx_q, 1'b0} +: 2];
  wire          has_addr = kind[1];
  wire          is_wr    = kind[0];
  wire [DIVW-1:0] half_m1 = fast_q ? DIVW'(HALF_FAST - 1) : DIVW'(HALF_SLOW - 1);
  wire          tick     = busy_q && (div_q == half_m1);
  wire [CW-1:0] wbase    = {reg_addr[AW-2:0], 2'b00};
  wire [CW-1:0] nxt      = bytecnt + CW'(1);
  wire [7:0]    first_d  = is_wr ? dbuf[0] : 8'h00;
  wire [7:0]    next_d   = is_wr ? dbuf[nxt] : 8'h00;

  assign spi_sck  = sck_q;
  assign spi_csn  = csn_q;
  assign spi_mosi = tx_q[7] & ~csn_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[AW-1]) begin
      for (int k = 0; k < 4; k++) reg_rdata[8*k +: 8] = dbuf[wbase + CW'(k)];
    end else begin
      case (reg_addr)
        A_CTRL: reg_rdata = (32'(cnt_q) << 8) | {24'b0, dp_q, idx_q, 1'b0, fast_q, atom_q, busy_q};
        A_STAT: reg_rdata = {29'b0, err_q, done_q, busy_q};
        A_ADDR: reg_rdata = {8'b0, addr_q};
        A_MLO:  reg_rdata = menu_lo;
        A_MHI:  reg_rdata = menu_hi;
        A_TYPE: reg_rdata = {16'b0, type_q};
        A_PRE:  reg_rdata = {24'b0, prefix_q};
        A_LOCK: reg_rdata = {31'b0, lock_q};
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menu_lo <= '0; menu_hi <= '0; type_q <= '0; prefix_q <= '0; lock_q <= 1'b0;
      addr_q <= '0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      idx_q <= '0; atom_q <= 1'b0; fast_q <= 1'b0; dp_q <= 1'b0; cnt_q <= '0;
      bytecnt <= '0; phase <= PH_IDLE; bitcnt <= '0; tx_q <= '0; rx_q <= '0;
      sck_q <= 1'b0; csn_q <= 1'b1; div_q <= '0;
      for (int i = 0; i < DATA_BYTES; i++) dbuf[i] <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr[AW-1]) begin
          for (int k = 0; k < 4; k++) dbuf[wbase + CW'(k)] <= reg_wdata[8*k +: 8];
        end else begin
          case (reg_addr)
            A_MLO:  if (!lock_q) menu_lo <= reg_wdata;
            A_MHI:  if (!lock_q) menu_hi <= reg_wdata;
            A_TYPE: if (!lock_q) type_q <= reg_wdata[15:0];
            A_PRE:  if (!lock_q) prefix_q <= reg_wdata[7:0];
            A_LOCK: if (reg_wdata[0]) lock_q <= 1'b1;
            A_ADDR: addr_q <= reg_wdata[23:0];
            A_STAT: begin
              if (reg_wdata[1]) done_q <= 1'b0;
              if (reg_wdata[2]) err_q <= 1'b0;
            end
            A_CTRL: if (reg_wdata[0]) begin
              if (busy_q) err_q <= 1'b1;
              else begin
                busy_q <= 1'b1;
                idx_q  <= reg_wdata[6:4];
                atom_q <= reg_wdata[1];
                fast_q <= reg_wdata[2] & FAST_CAPABLE;
                dp_q   <= reg_wdata[7];
                cnt_q  <= reg_wdata[8 +: CW];
                div_q  <= '0;
                sck_q  <= 1'b0;
                csn_q  <= 1'b0;
                bitcnt <= '0;
                phase  <= reg_wdata[1] ? PH_PRE : PH_OPC;
                tx_q   <= reg_wdata[1] ? prefix_q : start_op;
              end
            end
            default: ;
          endcase
        end
      end

      if (busy_q) begin
        div_q <= tick ? '0 : div_q + DIVW'(1);
        if (tick) begin
          if (phase == PH_GAP) begin
            if (bitcnt[0]) begin
              csn_q <= 1'b0; phase <= PH_OPC; tx_q <= opcode; bitcnt <= '0;
            end else bitcnt <= 3'd1;
          end else if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], spi_miso};
          end else begin
            sck_q <= 1'b0;
            if (bitcnt != 3'd7) begin
              bitcnt <= bitcnt + 3'd1;
              tx_q   <= {tx_q[6:0], 1'b0};
            end else begin
              bitcnt <= '0;
              case (phase)
                PH_PRE: begin phase <= PH_GAP; csn_q <= 1'b1; end
                PH_OPC: begin
                  if (has_addr) begin
                    phase <= PH_ADR; bytecnt <= '0; tx_q <= addr_q[23:16];
                  end else if (dp_q) begin
                    phase <= PH_DAT; bytecnt <= '0; tx_q <= first_d;
                  end else begin
                    phase <= PH_IDLE; busy_q <= 1'b0; done_q <= 1'b1; csn_q <= 1'b1;
                  end
                end
                PH_ADR: begin
                  if (bytecnt == CW'(2)) begin
                    if (dp_q) begin
                      phase <= PH_DAT; bytecnt <= '0; tx_q <= first_d;
                    end else begin
                      phase <= PH_IDLE; busy_q <= 1'b0; done_q <= 1'b1; csn_q <= 1'b1;
                    end
                  end else begin
                    bytecnt <= nxt;
                    tx_q    <= (bytecnt == '0) ? addr_q[15:8] : addr_q[7:0];
                  end
                end
                PH_DAT: begin
                  if (!is_wr) dbuf[bytecnt] <= rx_q;
                  if (bytecnt == cnt_q) begin
                    phase <= PH_IDLE; busy_q <= 1'b0; done_q <= 1'b1; csn_q <= 1'b1;
                  end else begin
                    bytecnt <= nxt; tx_q <= next_d;
                  end
                end
                default: ;
              endcase
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_menu_engine_chk.sv
module spi_menu_engine_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          spi_sck,
  input logic          spi_csn,
  input logic          spi_mosi,
  input logic          busy_q,
  input logic          done_q,
  input logic          err_q,
  input logic          lock_q,
  input logic [2:0]    idx_q,
  input logic [31:0]   menu_lo,
  input logic [31:0]   menu_hi
);
  wire ctrl_go = reg_we && (reg_addr == AW'(0)) && reg_wdata[0];
  wire menu_wr = reg_we && ((reg_addr == AW'(3)) || (reg_addr == AW'(4)));

  // R12
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sck);

  // R12
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // R1
  csn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> spi_csn);

  // R10
  busy_go_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_go && busy_q) |=> err_q);

  // R10
  busy_go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_go && busy_q) |=> $stable(idx_q));

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R8
  lock_menu_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && menu_wr) |=> $stable({menu_hi, menu_lo}));

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
endmodule

bind spi_menu_engine spi_menu_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .spi_sck(spi_sck), .spi_csn(spi_csn),
  .spi_mosi(spi_mosi), .busy_q(busy_q), .done_q(done_q), .err_q(err_q),
  .lock_q(lock_q), .idx_q(idx_q), .menu_lo(menu_lo), .menu_hi(menu_hi)
);

// File: tb/spi_menu_engine_test.sv
module spi_menu_engine_test;
  localparam int AW = 5;
  logic clk = 0, rst_n = 0, reg_we = 0, spi_miso = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_csn, spi_mosi;

  spi_menu_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  int exp_q[$];
  int last_gap = 0, last_high = 0;

  function automatic logic [7:0] pat(int n);
    return 8'((n * 17 + 60) & 255);
  endfunction

  function automatic logic [31:0] ctl(int idx, int dp, int cnt, int atom, int fast);
    return 32'(1 | (atom << 1) | (fast << 2) | (idx << 4) | (dp << 7) | ((cnt - 1) << 8));
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); reg_addr = AW'(a); #1 d = reg_rdata;
  endtask

  task automatic push(int b);
    exp_q.push_back(b);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(1, s);
      if (!s[0]) return;
    end
  endtask

  // Monitor: flash model and scoreboard
  initial begin
    bit prev_sck = 0, prev_csn = 1;
    int hi_run = 0, gap_run = 0, fb = 0, mb = 0, icnt = 0;
    logic [7:0] ms = '0, ib = '0;
    forever begin
      @(negedge clk);
      if (spi_sck) hi_run++;
      else if (prev_sck) begin last_high = hi_run; hi_run = 0; end
      if (!spi_csn && prev_csn) begin
        last_gap = gap_run; fb = 0; mb = 0; icnt = 0; ms = pat(0); spi_miso = ms[7];
      end
      if (spi_csn) gap_run++; else gap_run = 0;
      if (!spi_csn && spi_sck && !prev_sck) begin
        ib = {ib[6:0], spi_mosi}; icnt++;
        if (icnt == 8) begin
          int e;
          icnt = 0;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
          chk(e == int'(ib), "R12 frame byte", ib, e);
        end
      end
      if (!spi_csn && !spi_sck && prev_sck) begin
        mb++;
        if (mb == 8) begin mb = 0; fb++; ms = pat(fb); end
        else ms = {ms[6:0], 1'b0};
        spi_miso = ms[7];
      end
      if (spi_csn && !prev_csn) begin
        int e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : -2;
        chk(e == -1, "R12 frame end", 0, e);
      end
      prev_sck = spi_sck; prev_csn = spi_csn;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(1, d); chk(d == 0, "R1 status after reset", d, 0);
    chk(spi_csn == 1, "R1 csn idle", spi_csn, 1);
    chk(spi_sck == 0, "R1 sck idle", spi_sck, 0);

    // R2 R3 R6 programming
    wr(3, 32'h059F0306); wr(4, 32'hAB0B2002); wr(5, 32'h6F09);
    wr(6, 32'h06); wr(2, 32'hAB123456);
    rd(3, d); chk(d == 32'h059F0306, "R2 menu low readback", d, 32'h059F0306);
    rd(5, d); chk(d == 32'h6F09, "R3 type readback", d, 32'h6F09);
    rd(2, d); chk(d == 32'h00123456, "R6 address upper bits dropped", d, 32'h00123456);

    // R9 R4 R5 no-data cycle, entry 0
    push(8'h06); push(-1);
    wr(0, ctl(0, 0, 1, 0, 0)); wait_idle();
    rd(1, d); chk(d == 32'h2, "R9 R4 done after opcode-only cycle", d, 2);
    wr(1, 32'h2); rd(1, d); chk(d == 0, "R5 done cleared by write one", d, 0);

    // R11 R6 atomic prefix then erase with address
    push(8'h06); push(-1); push(8'h20); push(8'h12); push(8'h34); push(8'h56); push(-1);
    wr(0, ctl(5, 0, 1, 1, 0)); wait_idle();
    chk(last_gap >= 10, "R11 chip select gap after prefix", last_gap, 10);
    wr(1, 32'h6);

    // R3 R7 read with address, 8 bytes, slow clock
    push(8'h03); push(8'h12); push(8'h34); push(8'h56);
    for (int i = 0; i < 8; i++) push(0);
    push(-1);
    wr(0, ctl(1, 1, 8, 0, 0)); wait_idle();
    for (int w = 0; w < 2; w++) begin
      logic [31:0] e;
      for (int k = 0; k < 4; k++) e[8*k +: 8] = pat(4 + 4*w + k);
      rd(16 + w, d); chk(d == e, "R7 R3 read data stored ascending", d, e);
    end
    chk(last_high == 5, "R13 slow sck high time", last_high, 5);
    wr(1, 32'h6);

    // R7 write with address, 5 bytes
    wr(16, 32'h44332211); wr(17, 32'h88776655);
    push(8'h02); push(8'h12); push(8'h34); push(8'h56);
    push(8'h11); push(8'h22); push(8'h33); push(8'h44); push(8'h55); push(-1);
    wr(0, ctl(4, 1, 5, 0, 0)); wait_idle();
    wr(1, 32'h6);

    // R3 read without address, 3 bytes
    push(8'h9F); push(0); push(0); push(0); push(-1);
    wr(0, ctl(2, 1, 3, 0, 0)); wait_idle();
    rd(16, d);
    chk((d & 32'hFFFFFF) == {8'h0, pat(3), pat(2), pat(1)}, "R3 read no address data",
        d & 32'hFFFFFF, {8'h0, pat(3), pat(2), pat(1)});
    wr(1, 32'h6);

    // R7 R13 full 64-byte write on fast clock
    for (int w = 0; w < 16; w++) begin
      logic [31:0] v;
      for (int k = 0; k < 4; k++) v[8*k +: 8] = 8'(((4*w + k) * 7 + 1) & 255);
      wr(16 + w, v);
    end
    push(8'h02); push(8'h12); push(8'h34); push(8'h56);
    for (int i = 0; i < 64; i++) push((i * 7 + 1) & 255);
    push(-1);
    wr(0, ctl(4, 1, 64, 0, 1)); wait_idle();
    chk(last_high == 3, "R13 fast sck high time", last_high, 3);
    wr(1, 32'h6);

    // R10 control write during a cycle
    push(8'h9F); push(0); push(0); push(0); push(-1);
    wr(0, ctl(2, 1, 3, 0, 0)); wr(0, ctl(1, 1, 2, 0, 0));
    rd(1, d); chk(d == 32'h5, "R10 error while busy", d, 5);
    wait_idle();
    rd(1, d); chk(d == 32'h6, "R10 first cycle completes, error kept", d, 6);
    wr(1, 32'h6); rd(1, d); chk(d == 0, "R5 error cleared by write one", d, 0);

    // R8 lock
    wr(7, 32'h1);
    wr(3, 32'hFFFFFFFF); wr(5, 32'h0); wr(6, 32'hEE);
    rd(3, d); chk(d == 32'h059F0306, "R8 menu frozen", d, 32'h059F0306);
    rd(5, d); chk(d == 32'h6F09, "R8 type frozen", d, 32'h6F09);
    rd(6, d); chk(d == 32'h06, "R8 prefix frozen", d, 6);
    rd(7, d); chk(d == 32'h1, "R8 lock reads set", d, 1);
    push(8'h05); push(0); push(-1);
    wr(0, ctl(3, 1, 1, 0, 0)); wait_idle();
    rd(16, d); chk(d[7:0] == pat(1), "R8 frozen type still reads", d[7:0], pat(1));

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all expected frames seen", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule